// File: doc/BRIEF.md
# Power-Up Strap Mode Latch

This block picks the operating mode of the device once per power cycle. When the external reset pin goes from high to low, it reads two bus-control strap pins and a small group of upper address-port strap pins, then selects one of three modes: normal operation, in-system disable or a reserved test mode. The reset pin and the straps pass through one shared synchronizer. The falling edge is found by comparing the synchronized reset level with its value one clock earlier, so each falling edge gives exactly one clean sample.

The chosen mode is held in a sticky register. Later reset pulses and strap changes do not affect it, and only the power-on reset clears it. While in-system disable is active, the block overrides the output enables going to the pad ring and forces every enable off. The exception is a parameterised set of exempt pads: the oscillator output and the reset-status output stay under core control. In every other mode, and before a mode has been chosen, the core output enables pass straight through.

Top module: `strap_mode_ctrl`

## Requirements
- R1: Straps are taken only at a high-to-low transition of `rst_pin`. Strap values applied while reset is high, or changed one cycle after the transition, have no effect. With `SYNC_STAGES`=2 the flags change on the third rising clock edge after `rst_pin` falls and not earlier.
- R2: After `por_n` is released with `rst_pin` high, `mode_decided`, `mode_normal`, `mode_disable` and `mode_test` are all 0, and `pad_oe` equals `core_oe`.
- R3: If every bit of `addr_strap` is 0 at the sampling edge, only `mode_test` is set, whatever the levels of `ale_strap` and `psen_strap`.
- R4: If at least one bit of `addr_strap` is 1, `ale_strap` is 0 and `psen_strap` is 1 at the sampling edge, only `mode_disable` is set.
- R5: Any other strap pattern at the sampling edge sets only `mode_normal`.
- R6: Once `mode_decided` is 1, further `rst_pin` pulses and strap changes leave all four mode outputs unchanged.
- R7: While `mode_disable` is 1, every `pad_oe` bit outside `EXEMPT_MASK` is 0. Every bit inside `EXEMPT_MASK` (by default bit 0 for the oscillator and bit 7 for the reset status) equals the matching `core_oe` bit.
- R8: While `mode_disable` is 0, `pad_oe` equals `core_oe`.
- R9: Asserting `por_n` clears a previously chosen mode, and the next falling reset edge chooses again.
- R10: If `rst_pin` is already low when `por_n` is released, this counts as a falling edge. The mode is decided from the straps on the third rising clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| ale_strap | input | 1 | Address-latch-enable strap level |
| psen_strap | input | 1 | Program-store-enable strap level |
| addr_strap | input | ADDR_STRAPS | Upper address-port strap levels |
| core_oe | input | N_PADS | Output enables requested by the core |
| pad_oe | output | N_PADS | Output enables delivered to the pad ring |
| mode_decided | output | 1 | A mode has been latched this power cycle |
| mode_normal | output | 1 | Normal operation selected |
| mode_disable | output | 1 | In-system disable selected |
| mode_test | output | 1 | Reserved test mode selected |

## Verification
Two things can coincide in one cycle: the reset-edge sample and a strap change. The bench changes the straps one cycle after `rst_pin` falls, and again on every later reset pulse. The mode must still match the straps that were present just before the fall. The disable override and a change of `core_oe` can also meet in the same cycle. Every `core_oe` value is applied with the mode held fixed, and `pad_oe` is compared with the masked value that the bench computes.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

   typedef enum logic [1:0] {
      MODE_NONE    = 2'd0,
      MODE_NORMAL  = 2'd1,
      MODE_DISABLE = 2'd2,
      MODE_TEST    = 2'd3
   } strap_mode_e;

   // Test mode wins when no address strap is high; disable needs ALE low, PSEN high.
   function automatic strap_mode_e decode_straps(input logic ale,
                                                 input logic psen,
                                                 input logic any_addr_high);
      strap_mode_e m;
      if (!any_addr_high)
         m = MODE_TEST;
      else if (!ale && psen)
         m = MODE_DISABLE;
      else
         m = MODE_NORMAL;
      return m;
   endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int          WIDTH     = 1,
   parameter int          STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("strap_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("strap_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/strap_mode_latch.sv
module strap_mode_latch
   import strap_mode_pkg::*;
#(
   parameter int ADDR_STRAPS = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rst_level,
   input  logic                   ale,
   input  logic                   psen,
   input  logic [ADDR_STRAPS-1:0] addr,
   output logic                   rst_fall,
   output strap_mode_e            mode
);

   if (ADDR_STRAPS < 1) begin : g_bad_addr
      $error("strap_mode_latch: ADDR_STRAPS must be at least 1");
   end

   logic        rst_prev;
   strap_mode_e mode_q;

   assign rst_fall = rst_prev & ~rst_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_prev <= 1'b1;
         mode_q   <= MODE_NONE;
      end else begin
         rst_prev <= rst_level;
         if (rst_fall && (mode_q == MODE_NONE))
            mode_q <= decode_straps(ale, psen, |addr);
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/pad_oe_gate.sv
module pad_oe_gate #(
   parameter int                N_PADS      = 8,
   parameter logic [N_PADS-1:0] EXEMPT_MASK = '0
) (
   input  logic              force_off,
   input  logic [N_PADS-1:0] core_oe,
   output logic [N_PADS-1:0] pad_oe
);

   if (N_PADS < 1) begin : g_bad_pads
      $error("pad_oe_gate: N_PADS must be at least 1");
   end

   for (genvar p = 0; p < N_PADS; p++) begin : g_pad
      if (EXEMPT_MASK[p]) begin : g_exempt
         assign pad_oe[p] = core_oe[p];
      end else begin : g_gated
         assign pad_oe[p] = core_oe[p] & ~force_off;
      end
   end

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
   import strap_mode_pkg::*;
#(
   parameter int                N_PADS      = 8,
   parameter int                ADDR_STRAPS = 3,
   parameter int                SYNC_STAGES = 2,
   parameter logic [N_PADS-1:0] EXEMPT_MASK = 8'h81
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   rst_pin,
   input  logic                   ale_strap,
   input  logic                   psen_strap,
   input  logic [ADDR_STRAPS-1:0] addr_strap,
   input  logic [N_PADS-1:0]      core_oe,
   output logic [N_PADS-1:0]      pad_oe,
   output logic                   mode_decided,
   output logic                   mode_normal,
   output logic                   mode_disable,
   output logic                   mode_test
);

   localparam int SYNC_W = ADDR_STRAPS + 3;

   logic [SYNC_W-1:0] raw_vec;
   logic [SYNC_W-1:0] sync_vec;
   logic              rst_fall;
   strap_mode_e       mode;

   assign raw_vec = {rst_pin, ale_strap, psen_strap, addr_strap};

   strap_sync #(
      .WIDTH     (SYNC_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL ({SYNC_W{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   strap_mode_latch #(
      .ADDR_STRAPS (ADDR_STRAPS)
   ) u_latch (
      .clk       (clk),
      .rst_n     (por_n),
      .rst_level (sync_vec[SYNC_W-1]),
      .ale       (sync_vec[SYNC_W-2]),
      .psen      (sync_vec[SYNC_W-3]),
      .addr      (sync_vec[ADDR_STRAPS-1:0]),
      .rst_fall  (rst_fall),
      .mode      (mode)
   );

   assign mode_decided = (mode != MODE_NONE);
   assign mode_normal  = (mode == MODE_NORMAL);
   assign mode_disable = (mode == MODE_DISABLE);
   assign mode_test    = (mode == MODE_TEST);

   pad_oe_gate #(
      .N_PADS      (N_PADS),
      .EXEMPT_MASK (EXEMPT_MASK)
   ) u_gate (
      .force_off (mode_disable),
      .core_oe   (core_oe),
      .pad_oe    (pad_oe)
   );

endmodule

// File: rtl/strap_mode_ctrl_chk.sv
module strap_mode_ctrl_chk #(
   parameter int                N_PADS      = 8,
   parameter logic [N_PADS-1:0] EXEMPT_MASK = 8'h81
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_fall,
   input logic [N_PADS-1:0] core_oe,
   input logic [N_PADS-1:0] pad_oe,
   input logic              mode_decided,
   input logic              mode_normal,
   input logic              mode_disable,
   input logic              mode_test
);

   AST_ONE_MODE: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({mode_normal, mode_disable, mode_test})
      && (mode_decided == ($countones({mode_normal, mode_disable, mode_test}) == 1))); // R5

   AST_DECIDE_ON_FALL: assert property (@(posedge clk) disable iff (!por_n)
      $rose(mode_decided) |-> $past(rst_fall)); // R1

   AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      mode_decided |=> $stable({mode_normal, mode_disable, mode_test})); // R6

   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!por_n)
      mode_disable |-> ((pad_oe & ~EXEMPT_MASK) == '0)); // R7

   AST_EXEMPT_PASS: assert property (@(posedge clk) disable iff (!por_n)
      mode_disable |-> ((pad_oe & EXEMPT_MASK) == (core_oe & EXEMPT_MASK))); // R7

   AST_OE_PASS: assert property (@(posedge clk) disable iff (!por_n)
      !mode_disable |-> (pad_oe == core_oe)); // R8

endmodule

bind strap_mode_ctrl strap_mode_ctrl_chk #(
   .N_PADS      (N_PADS),
   .EXEMPT_MASK (EXEMPT_MASK)
) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .rst_fall     (rst_fall),
   .core_oe      (core_oe),
   .pad_oe       (pad_oe),
   .mode_decided (mode_decided),
   .mode_normal  (mode_normal),
   .mode_disable (mode_disable),
   .mode_test    (mode_test)
);

// File: tb/strap_mode_ctrl_test.sv
`timescale 1ns/1ps
module strap_mode_ctrl_test;

   localparam int          NP   = 8;
   localparam logic [7:0]  EXM  = 8'h81;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          rst_pin = 1'b1;
   logic          ale_strap = 1'b1;
   logic          psen_strap = 1'b1;
   logic [2:0]    addr_strap = 3'b111;
   logic [NP-1:0] core_oe = '0;
   logic [NP-1:0] pad_oe;
   logic          mode_decided, mode_normal, mode_disable, mode_test;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   strap_mode_ctrl uut (
      .clk          (clk),
      .por_n        (por_n),
      .rst_pin      (rst_pin),
      .ale_strap    (ale_strap),
      .psen_strap   (psen_strap),
      .addr_strap   (addr_strap),
      .core_oe      (core_oe),
      .pad_oe       (pad_oe),
      .mode_decided (mode_decided),
      .mode_normal  (mode_normal),
      .mode_disable (mode_disable),
      .mode_test    (mode_test)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {decided, normal, disable, test}
   function automatic logic [3:0] exp_flags(input logic [4:0] c);
      if (c[2:0] == 3'b000)             return 4'b1001;
      else if (!c[4] && c[3])           return 4'b1010;
      else                              return 4'b1100;
   endfunction

   function automatic logic [3:0] flags();
      return {mode_decided, mode_normal, mode_disable, mode_test};
   endfunction

   task automatic set_straps(input logic [4:0] c);
      ale_strap  = c[4];
      psen_strap = c[3];
      addr_strap = c[2:0];
   endtask

   task automatic power_cycle(input logic rst_level);
      @(negedge clk);
      por_n   = 1'b0;
      rst_pin = rst_level;
      repeat (2) @(posedge clk);
      @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      for (int c = 0; c < 32; c++) begin
         logic [4:0] cs = 5'(c);
         logic [3:0] ef = exp_flags(cs);
         set_straps(~cs);
         core_oe = 8'hA5;
         power_cycle(1'b1);
         #1;
         if (c == 0) check("R2 reset flags", 32'(flags()), 32'h0);
         else        check("R9 por clears mode", 32'(flags()), 32'h0);
         check("R2 reset oe pass", 32'(pad_oe), 32'hA5);
         // strap wiggle while reset held high
         @(negedge clk); set_straps(cs);
         repeat (3) @(posedge clk);
         @(negedge clk); set_straps(~cs);
         repeat (3) @(posedge clk);
         #1 check("R1 no decide while reset high", 32'(flags()), 32'h0);
         @(negedge clk); set_straps(cs);
         repeat (3) @(posedge clk);
         @(negedge clk); rst_pin = 1'b0;
         @(posedge clk);
         @(negedge clk); set_straps(~cs);   // change one cycle after the fall
         @(posedge clk);
         #1 check("R1 not before third edge", 32'(flags()), 32'h0);
         @(posedge clk);
         #1;
         if (ef[0])      check("R3 test mode", 32'(flags()), 32'(ef));
         else if (ef[1]) check("R4 disable mode", 32'(flags()), 32'(ef));
         else            check("R5 normal mode", 32'(flags()), 32'(ef));
         for (int v = 0; v < 256; v++) begin
            core_oe = 8'(v);
            #1;
            if (ef[1]) check("R7 disable oe mask", 32'(pad_oe), 32'(8'(v) & EXM));
            else       check("R8 oe pass", 32'(pad_oe), 32'(v));
         end
         // later reset pulses with new straps
         for (int p = 0; p < 2; p++) begin
            @(negedge clk); rst_pin = 1'b1; set_straps(cs ^ 5'(5 + 7*p));
            repeat (4) @(posedge clk);
            @(negedge clk); rst_pin = 1'b0;
            @(posedge clk);
            @(negedge clk); set_straps(~cs);
            repeat (4) @(posedge clk);
            #1 check("R6 mode sticky", 32'(flags()), 32'(ef));
         end
      end
      // reset pin already low at power-on release
      for (int c = 0; c < 32; c += 3) begin
         logic [4:0] cs = 5'(c);
         set_straps(cs);
         power_cycle(1'b0);
         repeat (2) @(posedge clk);
         #1 check("R10 not before third edge", 32'(flags()), 32'h0);
         @(posedge clk);
         #1 check("R10 decide at release", 32'(flags()), 32'(exp_flags(cs)));
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule